// File: doc/BRIEF.md
# Flow-through burst SRAM with pipelined writes

This block is a clocked model of a synchronous static RAM. Reads use flow-through timing, and writes have a one-cycle data lag, so the bus never needs a turnaround cycle. On every enabled rising edge the block samples three things: the address, the load/advance strobe and the direction. Write data and byte-lane enables are taken on the next enabled edge, and the array is written on that edge. Read data for an address appears combinationally just after the edge that samples the address. Because of this, a write followed at once by a read of the same word returns the new data with no idle cycle.

An access opened by a load cycle can continue as a four-word burst. Each advance cycle steps only the two lowest address bits. The order comes from a mode input: linear order (offset plus step, modulo 4) or interleaved order (offset XOR step). A burst keeps the direction chosen at its load cycle. The upper address bits never change during a burst. The burst wraps inside its group of four words.

An inactive clock-enable makes the whole edge count for nothing. A load cycle with the chip disabled deselects the device and ends any burst. The word width is set by the number of 9-bit byte lanes (4 lanes for 36 bits, 2 lanes for 18 bits), and the depth is set by the address width.

Top module: `flowthru_sram`

## Requirements
- R1: On an enabled edge with `adv_ld`=0, `chip_en`=1 and `we_n`=0, a write access opens at `addr`. The data on `din` at the next enabled edge is stored at that address.
- R2: In a write, lane i covers bits [9i+8:9i]. Lane i is written only when `bw_n[i]`=0. A lane with `bw_n[i]`=1 keeps its old content.
- R3: On an enabled edge with `adv_ld`=0, `chip_en`=1 and `we_n`=1, a read opens. Right after that edge, `dout` shows the addressed word and `dout_vld`=1, provided `oe_n`=0.
- R4: A read of an address on the enabled edge right after a write load of the same address returns the word written on that edge.
- R5: An edge with `cen_n`=1 is ignored. No input is sampled, no word is written and the burst position does not change.
- R6: With `mode`=0, each advance cycle (`adv_ld`=1) of an open access moves the two low address bits to (start + step) mod 4. Step counts advances since the load.
- R7: With `mode`=1, each advance cycle moves the two low address bits to start XOR step.
- R8: The upper address bits stay as loaded. After the fourth word the burst returns to its start offset, with no carry into the upper bits.
- R9: Advance cycles keep the read/write direction of the load cycle. `we_n` and `chip_en` are ignored on advance cycles.
- R10: An enabled edge with `adv_ld`=0 and `chip_en`=0 deselects the device. After it, `dout_vld`=0, and later advance cycles neither write nor read until the next load.
- R11: While `oe_n`=1, or while no read is open, `dout_vld`=0 and `dout` is all zeros.
- R12: Reset (`rst_n`=0) closes any open access, so `dout_vld`=0. Array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| cen_n | input | 1 | Active-low clock enable; high ignores the edge |
| we_n | input | 1 | Active-low write select, sampled on load cycles |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| chip_en | input | 1 | Active-high chip enable, sampled on load cycles |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| bw_n | input | LANES | Active-low byte-lane write enables, one cycle after the address |
| din | input | 9*LANES | Write data, one cycle after the address |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 9*LANES | Read data, zero when not driven |
| dout_vld | output | 1 | High when `dout` is driven |

## Verification
A vector table runs a write followed at once by a read of the same word, which separates a correct one-cycle data lag from an off-by-one pipeline. A linear write burst starts at offset 2 and runs past its fourth word, so wrap and no-carry errors leave a wrong word in the array. An interleaved read burst starts at offset 3 and shows the descending 3,2,1,0 order, which linear order cannot produce. Directed runs then cover a partial-lane write, a deselect in the middle of a burst followed by advances that must not write, a stalled edge in the middle of a write burst that must neither write nor step, and a linear read wrap.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
    localparam int unsigned BYTE_W    = 9;
    localparam int unsigned BURST_LEN = 4;
    localparam int unsigned OFS_W     = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_ADV   = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;
endpackage

// File: rtl/ftsram_burst_seq.sv
module ftsram_burst_seq
    import ftsram_pkg::*;
(
    input  logic             interleave_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [OFS_W-1:0] step_i,
    output logic [OFS_W-1:0] ofs_o
);
    always_comb begin
        if (interleave_i) ofs_o = start_i ^ step_i;
        else              ofs_o = start_i + step_i;
    end
endmodule

// File: rtl/ftsram_ctrl.sv
module ftsram_ctrl
    import ftsram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          we_n,
    input  logic          adv_ld,
    input  logic          chip_en,
    input  logic          mode,
    input  logic [AW-1:0] addr,
    output logic          acc_vld_o,
    output logic          acc_wr_o,
    output logic [AW-1:0] acc_addr_o,
    output logic          commit_o
);
    localparam logic [OFS_W-1:0] STEP_ONE = 1;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] step;
    } acc_t;

    acc_t             st_d, st_q;
    cmd_e             cmd;
    logic [OFS_W-1:0] step_nx;
    logic [OFS_W-1:0] ofs_nx;

    always_comb begin
        if (cen_n)        cmd = CMD_HOLD;
        else if (adv_ld)  cmd = CMD_ADV;
        else if (chip_en) cmd = CMD_LOAD;
        else              cmd = CMD_DESEL;
    end

    assign step_nx = st_q.step + STEP_ONE;

    ftsram_burst_seq u_seq (
        .interleave_i (mode),
        .start_i      (st_q.start),
        .step_i       (step_nx),
        .ofs_o        (ofs_nx)
    );

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_LOAD: begin
                st_d.vld   = 1'b1;
                st_d.wr    = ~we_n;
                st_d.addr  = addr;
                st_d.start = addr[OFS_W-1:0];
                st_d.step  = '0;
            end
            CMD_ADV: begin
                if (st_q.vld) begin
                    st_d.step            = step_nx;
                    st_d.addr[OFS_W-1:0] = ofs_nx;
                end
            end
            CMD_DESEL: begin
                st_d.vld = 1'b0;
                st_d.wr  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_vld_o  = st_q.vld;
    assign acc_wr_o   = st_q.wr;
    assign acc_addr_o = st_q.addr;
    assign commit_o   = ~cen_n & st_q.vld & st_q.wr;

    a_r1_write_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_en && !we_n)
        |=> (st_q.vld && st_q.wr && st_q.addr == $past(addr)));

    a_r5_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(st_q));

    a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && st_q.vld && !mode)
        |=> (st_q.addr[OFS_W-1:0] == $past(st_q.addr[OFS_W-1:0]) + STEP_ONE));

    a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && st_q.vld)
        |=> (st_q.addr[AW-1:OFS_W] == $past(st_q.addr[AW-1:OFS_W])));

    a_r9_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && st_q.vld)
        |=> (st_q.vld && st_q.wr == $past(st_q.wr)));

    a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !chip_en) |=> !st_q.vld);
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned AW     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [LANES-1:0]        bw_n,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !bw_n[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

    a_r2_lanes_known: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(bw_n));
endmodule

// File: rtl/flowthru_sram.sv
module flowthru_sram
    import ftsram_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned AW    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    we_n,
    input  logic                    adv_ld,
    input  logic                    chip_en,
    input  logic                    mode,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*BYTE_W-1:0] din,
    input  logic                    oe_n,
    output logic [LANES*BYTE_W-1:0] dout,
    output logic                    dout_vld
);
    localparam int unsigned W = LANES * BYTE_W;

    logic          acc_vld, acc_wr, commit;
    logic [AW-1:0] acc_addr;
    logic [W-1:0]  rdata;

    ftsram_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cen_n      (cen_n),
        .we_n       (we_n),
        .adv_ld     (adv_ld),
        .chip_en    (chip_en),
        .mode       (mode),
        .addr       (addr),
        .acc_vld_o  (acc_vld),
        .acc_wr_o   (acc_wr),
        .acc_addr_o (acc_addr),
        .commit_o   (commit)
    );

    ftsram_array #(.LANES(LANES), .LANE_W(BYTE_W), .AW(AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .bw_n  (bw_n),
        .waddr (acc_addr),
        .wdata (din),
        .raddr (acc_addr),
        .rdata (rdata)
    );

    assign dout_vld = acc_vld & ~acc_wr & ~oe_n;
    assign dout     = dout_vld ? rdata : '0;

    a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_en && we_n) |=> (oe_n || dout_vld));
endmodule

// File: tb/flowthru_sram_tb.sv
module flowthru_sram_tb;
    localparam int LANES = 4;
    localparam int AW    = 6;
    localparam int W     = LANES * 9;

    localparam logic [W-1:0] D0 = 36'h123456789;
    localparam logic [W-1:0] W0 = 36'h000000F00;
    localparam logic [W-1:0] W1 = 36'h0A1A1A1A1;
    localparam logic [W-1:0] W2 = 36'h0B2B2B2B2;
    localparam logic [W-1:0] W3 = 36'h0C3C3C3C3;
    localparam logic [W-1:0] W4 = 36'h0D4D4D4D4;

    typedef struct packed {
        logic             cen_n, we_n, adv, ce;
        logic [LANES-1:0] bw;
        logic [AW-1:0]    a;
        logic             md;
        logic [W-1:0]     d;
        logic             oe_n;
        logic             ev;
        logic [W-1:0]     ed;
        logic [7:0]       rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,4'hF,6'h08,1'b0,36'h0,1'b0,1'b0,36'h0,8'd1},  // R1 write load
        '{1'b0,1'b1,1'b0,1'b1,4'h0,6'h08,1'b0,D0,   1'b0,1'b1,D0,   8'd4},  // R4 data + read same
        '{1'b0,1'b0,1'b0,1'b1,4'hF,6'h12,1'b0,36'h0,1'b0,1'b0,36'h0,8'd1},  // R1 burst write load
        '{1'b0,1'b1,1'b1,1'b1,4'h0,6'h00,1'b0,W0,   1'b0,1'b0,36'h0,8'd9},  // R9 we_n high, still write
        '{1'b0,1'b1,1'b1,1'b0,4'h0,6'h00,1'b0,W1,   1'b0,1'b0,36'h0,8'd9},  // R9
        '{1'b0,1'b1,1'b1,1'b1,4'h0,6'h00,1'b0,W2,   1'b0,1'b0,36'h0,8'd6},  // R6
        '{1'b0,1'b1,1'b1,1'b1,4'h0,6'h00,1'b0,W3,   1'b0,1'b0,36'h0,8'd6},  // R6
        '{1'b0,1'b1,1'b0,1'b0,4'h0,6'h00,1'b0,W4,   1'b0,1'b0,36'h0,8'd10}, // R10 deselect, R8 wrap write
        '{1'b0,1'b1,1'b0,1'b1,4'hF,6'h13,1'b1,36'h0,1'b0,1'b1,W1,   8'd3},  // R3 read load
        '{1'b0,1'b1,1'b1,1'b1,4'hF,6'h00,1'b1,36'h0,1'b0,1'b1,W4,   8'd7},  // R7 3^1
        '{1'b0,1'b1,1'b1,1'b1,4'hF,6'h00,1'b1,36'h0,1'b0,1'b1,W3,   8'd7},  // R7 3^2
        '{1'b0,1'b1,1'b1,1'b1,4'hF,6'h00,1'b1,36'h0,1'b0,1'b1,W2,   8'd7},  // R7 3^3
        '{1'b0,1'b1,1'b1,1'b1,4'hF,6'h00,1'b1,36'h0,1'b0,1'b1,W1,   8'd8},  // R8 wrap
        '{1'b0,1'b1,1'b1,1'b1,4'hF,6'h00,1'b1,36'h0,1'b1,1'b0,36'h0,8'd11}, // R11 oe_n high
        '{1'b1,1'b0,1'b1,1'b1,4'h0,6'h3F,1'b1,36'hFFFFFFFFF,1'b0,1'b1,W4,8'd5}, // R5 stall
        '{1'b0,1'b1,1'b1,1'b1,4'hF,6'h00,1'b1,36'h0,1'b0,1'b1,W3,   8'd7}   // R7 resume
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cen_n = 1'b0, we_n = 1'b1, adv_ld = 1'b0, chip_en = 1'b0;
    logic             mode = 1'b0, oe_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [LANES-1:0] bw_n = '1;
    logic [W-1:0]     din = '0;
    logic [W-1:0]     dout;
    logic             dout_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flowthru_sram #(.LANES(LANES), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .we_n(we_n), .adv_ld(adv_ld),
        .chip_en(chip_en), .mode(mode), .addr(addr), .bw_n(bw_n), .din(din),
        .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic cyc(input logic c, input logic w, input logic a, input logic e,
                       input logic [LANES-1:0] b, input logic [AW-1:0] ad,
                       input logic m, input logic [W-1:0] d, input logic o);
        @(negedge clk);
        cen_n = c; we_n = w; adv_ld = a; chip_en = e;
        bw_n = b; addr = ad; mode = m; din = d; oe_n = o;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic ev, input logic [W-1:0] ed);
        logic [W-1:0] exp_d;
        exp_d = ev ? ed : '0;
        checks++;
        if (dout_vld !== ev || dout !== exp_d) begin
            failures++;
            $display("FAIL %s: dout_vld=%b dout=%h, expected dout_vld=%b dout=%h",
                     req, dout_vld, dout, ev, exp_d);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset closes the access
        repeat (3) @(posedge clk);
        #2;
        chk("R12 in reset", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0, 1'b0);
        chk("R12 after reset, advance with nothing open", 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].cen_n, VEC[i].we_n, VEC[i].adv, VEC[i].ce, VEC[i].bw,
                VEC[i].a, VEC[i].md, VEC[i].d, VEC[i].oe_n);
            chk($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].ed);
        end

        // R2: partial lane write keeps lanes 1 and 3
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '1,      6'h20, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 6'h20, 1'b0, 36'hFFFFFFFFF, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'b1010, 6'h20, 1'b0, '0, 1'b0);
        chk("R2 lane mask", 1'b1, {9'h1FF, 9'h000, 9'h1FF, 9'h000});

        // R10: deselect mid-burst, later advances must not write
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '1,   6'h22, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 6'h21, 1'b0, 36'h0000000AB, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h00, 1'b0, 36'h000000005, 1'b0);
        chk("R10 deselected", 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 6'h00, 1'b0, 36'h000000007, 1'b0);
        chk("R10 advance after deselect", 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h22, 1'b0, 36'h000000009, 1'b0);
        chk("R10 word past deselect untouched", 1'b1, 36'h0000000AB);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, '1,   6'h21, 1'b0, '0, 1'b0);
        chk("R1 word before deselect stored", 1'b1, 36'h000000005);

        // R5: stalled edge inside a write burst neither writes nor steps
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '1,   6'h31, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 6'h30, 1'b0, 36'h0000000CC, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'h00, 1'b0, 36'h000000011, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 6'h00, 1'b0, 36'h0000000EE, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, '1,   6'h00, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, '1,   6'h31, 1'b0, '0, 1'b0);
        chk("R5 stalled edge wrote nothing", 1'b1, 36'h0000000CC);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, '1,   6'h30, 1'b0, '0, 1'b0);
        chk("R5 word before stall stored", 1'b1, 36'h000000011);

        // R6 and R8: linear read burst from offset 2 wraps
        cyc(1'b0, 1'b1, 1'b0, 1'b1, '1, 6'h12, 1'b0, '0, 1'b0);
        chk("R6 load offset 2", 1'b1, W4);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0, 1'b0);
        chk("R6 offset 3", 1'b1, W1);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0, 1'b0);
        chk("R6 offset 0", 1'b1, W2);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0, 1'b0);
        chk("R6 offset 1", 1'b1, W3);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, 6'h00, 1'b0, '0, 1'b0);
        chk("R8 linear wrap to start", 1'b1, W4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule